// File: doc/BRIEF.md
# Command Buffer Front-End Sequencer

This block walks command buffers that software has placed in memory. A submission is a pair of packet addresses, start and end, where end is one past the last 64-bit command. Submissions queue in a small FIFO. For each buffer the controller runs an unpipelined loop. It computes the next read address, issues one single-beat 64-bit read on a simplified AXI-style read channel, and waits for the data. It then decodes the command and computes the next address again. The buffer is done when the next sequential address equals the end address. The controller then takes the next submission or goes idle.

Commands can write a graphics register, fire a draw, write a 32-bit label to memory (at once or after graphics work is done), poll a label until it equals a reference value, jump, call a sub-buffer, return, skip inline data, or do nothing (reserved codes). Only one address register feeds the next read. It selects either the incremented packet address or the address field of the last command. A label wait stores the label address in the same field that a jump target uses. A wait that does not match therefore re-reads the label after a programmable spin delay. There is no prefetch, so a label write can patch the low word of a later command in the same buffer.

Top module: `cmdq_frontend`

## Requirements
- R1: After reset, ar_valid, r_ready, reg_wr_valid, draw_valid, mem_wr_valid and busy are 0 and submit_ready is 1.
- R2: A submission is accepted on a clock edge where submit_valid and submit_ready are both 1. Buffers run in submission order, and submit_ready drops to 0 when FIFO_DEPTH submissions are waiting. A buffer with start equal to end fetches nothing. busy stays 1 until the last command of the last buffer has completed.
- R3: Each command is read from byte address packet<<3, with at most one read outstanding. While ar_valid is 1 and ar_ready is 0, ar_valid stays 1 and ar_addr does not change.
- R4: Command layout: opcode in bits [63:60], flag in [59], a 27-bit address field in [58:32], and a low word in [31:0]. Opcode 0x0 writes a register: it gives a one-cycle reg_wr_valid with aperture from [59:58], offset from [57:55] and data from the low word.
- R5: Opcode 0x1 gives a one-cycle draw_valid, with draw_data equal to the low word.
- R6: Opcode 0x2 writes a label: mem_wr_addr is field<<3 and mem_wr_data is the low word. With flag 0 the write is issued at once. With flag 1 nothing is issued, and nothing more is fetched, until gfx_done is 1.
- R7: Opcode 0x4 skips inline data: the next command is read from its own address plus 1 plus the field.
- R8: Opcode 0x5 jumps: the next command is read from the field address, and the buffer's end address becomes low word [26:0].
- R9: Opcode 0x6 calls. It saves its own address plus 1 and the current end address, then jumps to the field address with low word [26:0] as the new end. Opcode 0x7 returns to the saved address and saved end. The saved state has one level. A return with no call pending continues with the next command.
- R10: Opcode 0x8 waits on a label. It reads the word at the field address and compares that word's low 32 bits with the command's low word; both flag values test for equality. Polled data is never decoded as a command. On a match, the next command after the wait is read.
- R11: When a wait does not match, the label is read again. Between two accepted label reads there are at least spin_cycles+1 clock cycles.
- R12: A label write that patches the low word of a later command in the same buffer changes what that command does.
- R13: Opcodes 0x3 and 0x9 to 0xF produce no output and continue with the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| submit_valid | input | 1 | Submission offered |
| submit_start | input | 27 | First packet address of buffer |
| submit_end | input | 27 | Packet address one past the last command |
| submit_ready | output | 1 | Submission FIFO has room |
| spin_cycles | input | SPIN_W | Retry delay after a failed label poll |
| gfx_done | input | 1 | Earlier graphics work has finished |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | 30 | Read byte address |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Ready for read data |
| r_data | input | 64 | Read data |
| reg_wr_valid | output | 1 | Register write strobe |
| reg_wr_aperture | output | 2 | Register aperture |
| reg_wr_offset | output | 3 | Register offset |
| reg_wr_data | output | 32 | Register write data |
| draw_valid | output | 1 | Draw strobe |
| draw_data | output | 32 | Draw parameters |
| mem_wr_valid | output | 1 | Label write strobe |
| mem_wr_addr | output | 30 | Label byte address |
| mem_wr_data | output | 32 | Label value |
| busy | output | 1 | Work queued or in progress |

## Verification
The bench polls a label that first holds an all-zero word, which is itself a valid register-write encoding. A design that decoded polled data would emit a stray register write, and one that did not honour the spin delay would re-read too soon. Call followed by return is checked on the exact fetch address sequence; a design that did not restore the caller's end address would stop early or run on. A deferred label write is held back while gfx_done is low. The bench also fills the submission FIFO behind a stalled read channel to check backpressure, the held read address and order. Inline data skipped by a NOP, and a command patched by an earlier label write, show whether addresses are computed correctly and whether anything was prefetched.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int PKT_AW  = 27;          // packet (64-bit unit) address width
  localparam int BYTE_AW = PKT_AW + 3;  // byte address width

  localparam logic [3:0] OPC_REGW   = 4'h0;
  localparam logic [3:0] OPC_DRAW   = 4'h1;
  localparam logic [3:0] OPC_LWRITE = 4'h2;
  localparam logic [3:0] OPC_NOP    = 4'h4;
  localparam logic [3:0] OPC_JUMP   = 4'h5;
  localparam logic [3:0] OPC_CALL   = 4'h6;
  localparam logic [3:0] OPC_RET    = 4'h7;
  localparam logic [3:0] OPC_LWAIT  = 4'h8;

  typedef enum logic [3:0] {
    K_REGW, K_DRAW, K_LWRITE, K_NOP, K_JUMP, K_CALL, K_RET, K_WAIT, K_SKIP
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e           kind;
    logic                flag;
    logic [PKT_AW-1:0]   field;
    logic [1:0]          aper;
    logic [2:0]          offs;
    logic [31:0]         low;
  } cmd_dec_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UPDATE, ST_FETCH, ST_SPIN, ST_GFXWAIT
  } fe_state_e;
endpackage

// File: rtl/cmdq_submit_fifo.sv
module cmdq_submit_fifo #(
  parameter int WIDTH = 54,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic push_ok, pop_ok;

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign push_ok  = push & ~full;
  assign pop_ok   = pop & ~empty;
  assign pop_data = slot_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
    if (pop_ok)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
    if (push_ok && !pop_ok)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop_ok && !push_ok) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slot_q[wr_q] <= push_data;
  end

  // R2: the sequencer only pops a queue that holds a submission
  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic [63:0] word,
  output cmd_dec_t    dec
);
  logic [3:0] opc;
  assign opc = word[63:60];

  always_comb begin
    dec.flag  = word[59];
    dec.field = word[58:32];
    dec.aper  = word[59:58];
    dec.offs  = word[57:55];
    dec.low   = word[31:0];
    case (opc)
      OPC_REGW:   dec.kind = K_REGW;
      OPC_DRAW:   dec.kind = K_DRAW;
      OPC_LWRITE: dec.kind = K_LWRITE;
      OPC_NOP:    dec.kind = K_NOP;
      OPC_JUMP:   dec.kind = K_JUMP;
      OPC_CALL:   dec.kind = K_CALL;
      OPC_RET:    dec.kind = K_RET;
      OPC_LWAIT:  dec.kind = K_WAIT;
      default:    dec.kind = K_SKIP;   // R13 reserved codes
    endcase
  end
endmodule

// File: rtl/cmdq_spin.sv
module cmdq_spin #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (tick && !done) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cmdq_frontend.sv
module cmdq_frontend
  import cmdq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int SPIN_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               submit_valid,
  input  logic [PKT_AW-1:0]  submit_start,
  input  logic [PKT_AW-1:0]  submit_end,
  output logic               submit_ready,
  input  logic [SPIN_W-1:0]  spin_cycles,
  input  logic               gfx_done,
  output logic               ar_valid,
  input  logic               ar_ready,
  output logic [BYTE_AW-1:0] ar_addr,
  input  logic               r_valid,
  output logic               r_ready,
  input  logic [63:0]        r_data,
  output logic               reg_wr_valid,
  output logic [1:0]         reg_wr_aperture,
  output logic [2:0]         reg_wr_offset,
  output logic [31:0]        reg_wr_data,
  output logic               draw_valid,
  output logic [31:0]        draw_data,
  output logic               mem_wr_valid,
  output logic [BYTE_AW-1:0] mem_wr_addr,
  output logic [31:0]        mem_wr_data,
  output logic               busy
);
  localparam int SUB_W = 2 * PKT_AW;

  fe_state_e state_q, state_d;
  logic [PKT_AW-1:0] cmd_q, cmd_d, jmp_q, jmp_d, end_q, end_d;
  logic [PKT_AW-1:0] ret_q, ret_d, send_q, send_d;
  logic [31:0]       ref_q, ref_d;
  logic poll_q, poll_d, seq_q, seq_d, callp_q, callp_d, ardone_q, ardone_d;
  logic [BYTE_AW-1:0] araddr_q, araddr_d;
  logic regv_q, regv_d, drawv_q, drawv_d, memv_q, memv_d;
  logic [1:0]  rap_q, rap_d;
  logic [2:0]  rof_q, rof_d;
  logic [31:0] rdat_q, rdat_d, ddat_q, ddat_d, mdat_q, mdat_d;
  logic [BYTE_AW-1:0] madr_q, madr_d;

  logic fifo_pop, fifo_full, fifo_empty, spin_load, spin_done, r_fire;
  logic [SUB_W-1:0] fifo_out;
  logic [PKT_AW-1:0] pkt_inc, next_pkt;
  cmd_dec_t dec;

  cmdq_submit_fifo #(.WIDTH(SUB_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(submit_valid), .push_data({submit_start, submit_end}),
    .pop(fifo_pop), .pop_data(fifo_out),
    .full(fifo_full), .empty(fifo_empty));

  cmdq_decode u_dec (.word(r_data), .dec(dec));

  cmdq_spin #(.W(SPIN_W)) u_spin (
    .clk(clk), .rst_n(rst_n), .load(spin_load), .load_val(spin_cycles),
    .tick(state_q == ST_SPIN), .done(spin_done));

  assign submit_ready = ~fifo_full;
  assign ar_valid     = (state_q == ST_FETCH) & ~ardone_q;
  assign r_ready      = (state_q == ST_FETCH) & ardone_q;
  assign ar_addr      = araddr_q;
  assign r_fire       = r_valid & r_ready;
  assign busy         = (state_q != ST_IDLE) | ~fifo_empty;
  assign pkt_inc      = cmd_q + PKT_AW'(1);
  // sequential advance or a matched label uses the increment; else shared field
  assign next_pkt     = seq_q ? pkt_inc : jmp_q;

  assign reg_wr_valid    = regv_q;
  assign reg_wr_aperture = rap_q;
  assign reg_wr_offset   = rof_q;
  assign reg_wr_data     = rdat_q;
  assign draw_valid      = drawv_q;
  assign draw_data       = ddat_q;
  assign mem_wr_valid    = memv_q;
  assign mem_wr_addr     = madr_q;
  assign mem_wr_data     = mdat_q;

  always_comb begin
    state_d = state_q;  cmd_d = cmd_q;   jmp_d = jmp_q;   end_d = end_q;
    ret_d = ret_q;      send_d = send_q; ref_d = ref_q;   poll_d = poll_q;
    seq_d = seq_q;      callp_d = callp_q; ardone_d = ardone_q;
    araddr_d = araddr_q;
    regv_d = 1'b0; drawv_d = 1'b0; memv_d = 1'b0;
    rap_d = rap_q; rof_d = rof_q; rdat_d = rdat_q; ddat_d = ddat_q;
    madr_d = madr_q; mdat_d = mdat_q;
    fifo_pop = 1'b0; spin_load = 1'b0;
    case (state_q)
      ST_IDLE: if (!fifo_empty) begin
        fifo_pop = 1'b1;
        jmp_d    = fifo_out[SUB_W-1:PKT_AW];
        end_d    = fifo_out[PKT_AW-1:0];
        seq_d    = 1'b0;
        poll_d   = 1'b0;
        callp_d  = 1'b0;
        state_d  = ST_UPDATE;
      end
      ST_UPDATE: begin
        if (poll_q) begin
          araddr_d = {jmp_q, 3'b000};
          ardone_d = 1'b0;
          state_d  = ST_FETCH;
        end else if (next_pkt == end_q) begin
          state_d = ST_IDLE;
        end else begin
          cmd_d    = next_pkt;
          araddr_d = {next_pkt, 3'b000};
          ardone_d = 1'b0;
          state_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (ar_valid && ar_ready) ardone_d = 1'b1;
        if (r_fire) begin
          state_d = ST_UPDATE;
          if (poll_q) begin
            if (r_data[31:0] == ref_q) begin
              poll_d = 1'b0;
              seq_d  = 1'b1;
            end else begin
              spin_load = 1'b1;
              state_d   = ST_SPIN;
            end
          end else begin
            seq_d = 1'b1;
            case (dec.kind)
              K_REGW: begin
                regv_d = 1'b1; rap_d = dec.aper; rof_d = dec.offs; rdat_d = dec.low;
              end
              K_DRAW: begin
                drawv_d = 1'b1; ddat_d = dec.low;
              end
              K_LWRITE: begin
                madr_d = {dec.field, 3'b000};
                mdat_d = dec.low;
                if (dec.flag) state_d = ST_GFXWAIT;
                else          memv_d  = 1'b1;
              end
              K_NOP: begin
                seq_d = 1'b0; jmp_d = pkt_inc + dec.field;
              end
              K_JUMP: begin
                seq_d = 1'b0; jmp_d = dec.field; end_d = dec.low[PKT_AW-1:0];
              end
              K_CALL: begin
                seq_d = 1'b0; jmp_d = dec.field; end_d = dec.low[PKT_AW-1:0];
                ret_d = pkt_inc; send_d = end_q; callp_d = 1'b1;
              end
              K_RET: if (callp_q) begin
                seq_d = 1'b0; jmp_d = ret_q; end_d = send_q; callp_d = 1'b0;
              end
              K_WAIT: begin
                seq_d = 1'b0; jmp_d = dec.field; ref_d = dec.low; poll_d = 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
      ST_SPIN: if (spin_done) state_d = ST_UPDATE;
      ST_GFXWAIT: if (gfx_done) begin
        memv_d  = 1'b1;
        state_d = ST_UPDATE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cmd_q <= '0; jmp_q <= '0; end_q <= '0;
      ret_q <= '0; send_q <= '0; ref_q <= '0; poll_q <= 1'b0;
      seq_q <= 1'b0; callp_q <= 1'b0; ardone_q <= 1'b0; araddr_q <= '0;
      regv_q <= 1'b0; drawv_q <= 1'b0; memv_q <= 1'b0;
      rap_q <= '0; rof_q <= '0; rdat_q <= '0; ddat_q <= '0;
      madr_q <= '0; mdat_q <= '0;
    end else begin
      state_q <= state_d; cmd_q <= cmd_d; jmp_q <= jmp_d; end_q <= end_d;
      ret_q <= ret_d; send_q <= send_d; ref_q <= ref_d; poll_q <= poll_d;
      seq_q <= seq_d; callp_q <= callp_d; ardone_q <= ardone_d; araddr_q <= araddr_d;
      regv_q <= regv_d; drawv_q <= drawv_d; memv_q <= memv_d;
      rap_q <= rap_d; rof_q <= rof_d; rdat_q <= rdat_d; ddat_q <= ddat_d;
      madr_q <= madr_d; mdat_q <= mdat_d;
    end
  end

  // R1: nothing is requested from memory while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!ar_valid && !r_ready));
  // R3: a stalled read request keeps its address
  assert_ar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));
  // R6: a deferred label write stays quiet while graphics work is pending
  assert_defer_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GFXWAIT && !gfx_done) |=> !mem_wr_valid);
  // R10: polled label data never reaches a command output
  assert_poll_not_decoded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (r_fire && poll_q) |=> (!reg_wr_valid && !draw_valid && !mem_wr_valid));
  // R11: spinning issues no read
  assert_spin_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPIN) |-> !ar_valid);
endmodule

// File: tb/tb_cmdq_frontend.sv
module tb_cmdq_frontend;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        submit_valid, submit_ready, gfx_done, ar_valid, ar_ready, r_valid, r_ready;
  logic [26:0] submit_start, submit_end;
  logic [7:0]  spin_cycles;
  logic [29:0] ar_addr, mem_wr_addr;
  logic [63:0] r_data;
  logic        reg_wr_valid, draw_valid, mem_wr_valid, busy;
  logic [1:0]  reg_wr_aperture;
  logic [2:0]  reg_wr_offset;
  logic [31:0] reg_wr_data, draw_data, mem_wr_data;

  cmdq_frontend dut (
    .clk(clk), .rst_n(rst_n), .submit_valid(submit_valid), .submit_start(submit_start),
    .submit_end(submit_end), .submit_ready(submit_ready), .spin_cycles(spin_cycles),
    .gfx_done(gfx_done), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_aperture(reg_wr_aperture),
    .reg_wr_offset(reg_wr_offset), .reg_wr_data(reg_wr_data),
    .draw_valid(draw_valid), .draw_data(draw_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .busy(busy));

  // behavioural memory responder
  logic [63:0] mem [256];
  logic        ar_hold;
  assign ar_ready = ~ar_hold;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_data  <= '0;
    end else begin
      if (ar_valid && ar_ready) begin
        r_valid <= 1'b1;
        r_data  <= mem[ar_addr[10:3]];
      end else if (r_valid && r_ready) begin
        r_valid <= 1'b0;
      end
      if (mem_wr_valid) mem[mem_wr_addr[10:3]][31:0] <= mem_wr_data;
    end
  end

  // event and fetch logs, sampled mid-cycle
  int          cyc = 0, ev_n = 0, fe_n = 0;
  int          ev_k [256];
  logic [63:0] ev_v [256];
  logic [29:0] fe_a [256];
  int          fe_c [256];
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (reg_wr_valid) begin
      ev_k[ev_n[7:0]] = 1; ev_v[ev_n[7:0]] = {27'd0, reg_wr_aperture, reg_wr_offset, reg_wr_data};
      ev_n = ev_n + 1;
    end
    if (draw_valid) begin
      ev_k[ev_n[7:0]] = 2; ev_v[ev_n[7:0]] = {32'd0, draw_data}; ev_n = ev_n + 1;
    end
    if (mem_wr_valid) begin
      ev_k[ev_n[7:0]] = 3; ev_v[ev_n[7:0]] = {2'b00, mem_wr_addr, mem_wr_data}; ev_n = ev_n + 1;
    end
    if (ar_valid && ar_ready) begin
      fe_a[fe_n[7:0]] = ar_addr; fe_c[fe_n[7:0]] = cyc; fe_n = fe_n + 1;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] op, input logic fl,
                                     input logic [26:0] fld, input logic [31:0] lo);
    return {op, fl, fld, lo};
  endfunction
  function automatic logic [63:0] regw(input logic [31:0] d);
    return {4'h0, 2'b00, 3'b001, 23'd0, d};
  endfunction
  function automatic logic [63:0] rexp(input logic [31:0] d);
    return {27'd0, 2'b00, 3'b001, d};
  endfunction

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic submit(input logic [26:0] s, input logic [26:0] e);
    submit_valid = 1'b1; submit_start = s; submit_end = e;
    @(posedge clk); #1;
    submit_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 3000) begin step(1); n++; end
    if (busy) chk(1'b0, {req, " watchdog"}, 64'd1, 64'd0);
  endtask

  // table of single-command buffers: command, expected event kind, expected value
  localparam int NV = 7;
  localparam logic [63:0] V_CMD [NV] = '{
    64'h06800000_DEADBEEF, 64'h08000000_00000001, 64'h10000000_00030010,
    64'h20000040_CAFEF00D, 64'h3FFFFFFF_FFFFFFFF, 64'hC0000001_00000001,
    64'h40000000_12345678 };
  localparam int V_KIND [NV] = '{1, 1, 2, 3, 0, 0, 0};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0000000D_DEADBEEF, 64'h00000010_00000001, 64'h00000000_00030010,
    64'h00000200_CAFEF00D, 64'd0, 64'd0, 64'd0 };
  localparam string V_REQ [NV] = '{"R4", "R4", "R5", "R6", "R13", "R13", "R7"};

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b;
    int lbl_reads, min_gap, last_c;
    for (int i = 0; i < 256; i++) mem[i] = 64'h7000000000000000;
    rst_n = 1'b0; submit_valid = 1'b0; submit_start = '0; submit_end = '0;
    spin_cycles = 8'd0; gfx_done = 1'b1; ar_hold = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(!ar_valid && !r_ready, "R1 read idle", {62'd0, ar_valid, r_ready}, 64'd0);
    chk(!reg_wr_valid && !draw_valid && !mem_wr_valid, "R1 strobes", {61'd0, reg_wr_valid, draw_valid, mem_wr_valid}, 64'd0);
    chk(!busy && submit_ready, "R1 busy/ready", {62'd0, busy, submit_ready}, 64'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      mem[16] = V_CMD[i];
      b = ev_n;
      submit(27'd16, 27'd17);
      wait_idle(V_REQ[i]);
      if (V_KIND[i] == 0) chk(ev_n == b, V_REQ[i], 64'(ev_n - b), 64'd0);
      else chk(ev_n == b + 1 && ev_k[b] == V_KIND[i] && ev_v[b] == V_EXP[i], V_REQ[i], ev_v[b], V_EXP[i]);
    end

    // R7 NOP skips inline data
    mem[32] = mk(4'h4, 1'b0, 27'd2, 32'd0);
    mem[33] = regw(32'hBAD0); mem[34] = regw(32'hBAD1); mem[35] = regw(32'h1111);
    b = ev_n;
    submit(27'd32, 27'd36); wait_idle("R7");
    chk(ev_n == b + 1 && ev_v[b] == rexp(32'h1111), "R7 skip", ev_v[b], rexp(32'h1111));

    // R8 jump with new end
    mem[48] = mk(4'h5, 1'b0, 27'd56, 32'd58);
    mem[49] = regw(32'hBAD2);
    mem[56] = mk(4'h1, 1'b0, 27'd0, 32'h77); mem[57] = mk(4'h1, 1'b0, 27'd0, 32'h78);
    b = ev_n;
    submit(27'd48, 27'd49); wait_idle("R8");
    chk(ev_n == b + 2 && ev_v[b] == 64'h77 && ev_v[b+1] == 64'h78, "R8 jump", 64'(ev_n - b), 64'd2);

    // R9 call and return: fetch order 40,50,51,41 then idle
    mem[64] = mk(4'h6, 1'b0, 27'd80, 32'd82);
    mem[65] = regw(32'hA1);
    mem[80] = regw(32'hB1); mem[81] = mk(4'h7, 1'b0, 27'd0, 32'd0);
    b = ev_n; lbl_reads = fe_n;
    submit(27'd64, 27'd66); wait_idle("R9");
    chk(fe_n == lbl_reads + 4 && fe_a[lbl_reads+1] == 30'(80*8) && fe_a[lbl_reads+2] == 30'(81*8)
        && fe_a[lbl_reads+3] == 30'(65*8), "R9 call path", 64'(fe_a[lbl_reads+3]), 64'(65*8));
    chk(ev_n == b + 2 && ev_v[b] == rexp(32'hB1) && ev_v[b+1] == rexp(32'hA1), "R9 order", ev_v[b+1], rexp(32'hA1));

    // R9 return without a call
    mem[96] = mk(4'h7, 1'b0, 27'd0, 32'd0); mem[97] = regw(32'hC1);
    b = ev_n;
    submit(27'd96, 27'd98); wait_idle("R9");
    chk(ev_n == b + 1 && ev_v[b] == rexp(32'hC1), "R9 bare return", ev_v[b], rexp(32'hC1));

    // R10/R11 label wait with spin; label word all zero looks like a register write
    mem[112] = 64'd0;
    mem[128] = mk(4'h8, 1'b0, 27'd112, 32'd5); mem[129] = regw(32'hD1);
    spin_cycles = 8'd6;
    b = ev_n; last_c = fe_n;
    submit(27'd128, 27'd130);
    lbl_reads = 0;
    while (lbl_reads < 3) begin
      step(1);
      lbl_reads = 0;
      for (int k = last_c; k < fe_n; k++) if (fe_a[k] == 30'(112*8)) lbl_reads++;
    end
    chk(ev_n == b, "R10 polled data not decoded", 64'(ev_n - b), 64'd0);
    mem[112] = 64'd5;
    wait_idle("R10");
    lbl_reads = 0; min_gap = 1000; b = b;
    begin
      int prev = -1;
      for (int k = last_c; k < fe_n; k++) if (fe_a[k] == 30'(112*8)) begin
        lbl_reads++;
        if (prev >= 0 && fe_c[k] - prev < min_gap) min_gap = fe_c[k] - prev;
        prev = fe_c[k];
      end
    end
    chk(lbl_reads >= 4, "R11 re-poll", 64'(lbl_reads), 64'd4);
    chk(min_gap >= 7, "R11 spin gap", 64'(min_gap), 64'd7);
    chk(ev_n == b + 1 && ev_v[b] == rexp(32'hD1), "R10 continue after match", ev_v[b], rexp(32'hD1));

    // R10 reserved compare flag also tests equality
    mem[132] = mk(4'h8, 1'b1, 27'd112, 32'd5); mem[133] = regw(32'hE1);
    b = ev_n; last_c = fe_n;
    submit(27'd132, 27'd134); wait_idle("R10");
    chk(fe_n == last_c + 3 && ev_n == b + 1 && ev_v[b] == rexp(32'hE1), "R10 flag1 eq", 64'(fe_n - last_c), 64'd3);

    // R6 deferred label write
    gfx_done = 1'b0;
    mem[144] = mk(4'h2, 1'b1, 27'd113, 32'h99); mem[145] = regw(32'hF1);
    b = ev_n; last_c = fe_n;
    submit(27'd144, 27'd146);
    step(30);
    chk(ev_n == b && fe_n == last_c + 1, "R6 held while busy", 64'(ev_n - b), 64'd0);
    gfx_done = 1'b1;
    wait_idle("R6");
    chk(ev_n == b + 2 && ev_k[b] == 3 && ev_v[b+1] == rexp(32'hF1), "R6 released", 64'(ev_k[b]), 64'd3);
    chk(mem[113][31:0] == 32'h99, "R6 label value", {32'd0, mem[113][31:0]}, 64'h99);

    // R12 label write patches the next command
    mem[160] = mk(4'h2, 1'b0, 27'd161, 32'h12345678); mem[161] = regw(32'h0);
    b = ev_n;
    submit(27'd160, 27'd162); wait_idle("R12");
    chk(ev_n == b + 2 && ev_v[b+1] == rexp(32'h12345678), "R12 patched", ev_v[b+1], rexp(32'h12345678));

    // R2/R3 FIFO backpressure with a stalled read channel, then order; empty buffer fetches nothing
    ar_hold = 1'b1;
    for (int i = 0; i < 5; i++) mem[176 + 2*i] = regw(32'h100 + i);
    b = ev_n; last_c = fe_n;
    for (int i = 0; i < 5; i++) submit(27'(176 + 2*i), 27'(177 + 2*i));
    chk(!submit_ready, "R2 full", {63'd0, submit_ready}, 64'd0);
    chk(ar_valid && ar_addr == 30'(176*8), "R3 request", {34'd0, ar_addr}, 64'(176*8));
    step(5);
    chk(ar_valid && ar_addr == 30'(176*8), "R3 hold", {34'd0, ar_addr}, 64'(176*8));
    ar_hold = 1'b0;
    step(1);
    submit(27'd190, 27'd190);
    wait_idle("R2");
    chk(ev_n == b + 5 && ev_v[b] == rexp(32'h100) && ev_v[b+4] == rexp(32'h104), "R2 order", ev_v[b+4], rexp(32'h104));
    chk(fe_n == last_c + 5, "R2 empty buffer", 64'(fe_n - last_c), 64'd5);
    chk(!busy && submit_ready, "R2 idle at end", {62'd0, busy, submit_ready}, 64'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule